// File: doc/BRIEF.md
# Hexadecimal Seven-Segment Decoder with Blanking Chain

This block turns a 4-bit hexadecimal code into the seven drive lines of a common-anode display digit. Every segment line is active low, so a 0 lights that segment. It is purely combinational. The ten decimal values use the usual numeral shapes, and 10 to 15 show as A, b, C, d, E, F. The lowercase b and d keep those two apart from 8 and 0.

Three active-low controls sit on top of the decode. A blank input forces the digit dark. A lamp-test input lights every segment. A ripple input, together with a ripple output, lets a row of digits hide its leading zeroes. To build a row, tie the ripple input of the leftmost digit low and feed each digit's ripple output into the ripple input of the digit to its right. A zero then stays dark only while every digit to its left is also a dark zero. A zero that sits between other digits still shows.

Top module: `hexseg_digit`

## Requirements
- R1: `digit_val` is the code with bit 3 as the most significant bit. `seg_n` bit 0 drives segment a, bits 1 to 6 drive b, c, d, e, f, g, and a 0 lights a segment. With both controls released and no ripple blanking, codes 0 to 9 give the active-low patterns 0x40, 0x79, 0x24, 0x30, 0x19, 0x12, 0x02, 0x78, 0x00, 0x10 (written as {g,f,e,d,c,b,a}).
- R2: Code 6 lights segment a. Code 9 lights segment d.
- R3: Codes 10 to 15 give the active-low patterns 0x08, 0x03, 0x46, 0x21, 0x06, 0x0E (A, b, C, d, E, F).
- R4: When `blank_n` is 0, all seven `seg_n` lines are 1, whatever the other inputs are.
- R5: When `blank_n` is 1 and `lamp_test_n` is 0, all seven `seg_n` lines are 0, for every code and every ripple input.
- R6: When `rb_in_n` is 0, the code is 0 and `lamp_test_n` is 1, `rb_out_n` is 0 and all segments are off.
- R7: `rb_out_n` is 1 in every case that R6 does not cover, including a non-zero code or lamp test asserted.
- R8: When `rb_in_n` is 0 and the code is not zero, the digit decodes exactly as with `rb_in_n` at 1.
- R9: In a row of four digits chained as described above, only leading zeroes go dark. An embedded zero still shows, and an all-zero value darkens every digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digit_val | input | 4 | Hexadecimal code, bit 3 most significant |
| lamp_test_n | input | 1 | Active-low lamp test, lights all segments |
| blank_n | input | 1 | Active-low forced blank, highest priority |
| rb_in_n | input | 1 | Active-low ripple-blank request from the digit to the left |
| seg_n | output | 7 | Active-low segment drives, bit 0 = a through bit 6 = g |
| rb_out_n | output | 1 | Active-low ripple-blank pass-on to the digit to the right |

## Verification
Immediate assertions are evaluated each time the inputs change. They check the control priority: a blanked digit is dark, and a lamp test lights everything unless the digit is blanked. They also check that a low ripple output happens only for a dark zero without lamp test, and that no glyph lights fewer than two segments. Only the bench scenarios can show that each of the sixteen glyph shapes is correct under all eight control combinations. The bench also shows how a four-digit chain behaves: leading zeroes go dark while embedded zeroes stay lit, which no single-digit property can express.

// File: rtl/hexseg_pkg.sv
package hexseg_pkg;
    localparam int CODE_W = 4;
    localparam int SEG_W  = 7;
    localparam int NUM_CODES = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_W-1:0]  seg_t;

    // what the output stage must show
    typedef enum logic [1:0] {
        SHOW_GLYPH = 2'd0,
        SHOW_DARK  = 2'd1,
        SHOW_ALL   = 2'd2
    } show_e;

    typedef struct packed {
        show_e mode;
        logic  rip_out_n;
    } ctrl_t;
endpackage

// File: rtl/hexseg_glyph.sv
module hexseg_glyph
    import hexseg_pkg::*;
(
    input  code_t code,
    output seg_t  lit      // active high, bit 0 = a ... bit 6 = g
);
    seg_t lit_d;

    always_comb begin
        unique case (code)
            4'h0: lit_d = 7'h3F;
            4'h1: lit_d = 7'h06;
            4'h2: lit_d = 7'h5B;
            4'h3: lit_d = 7'h4F;
            4'h4: lit_d = 7'h66;
            4'h5: lit_d = 7'h6D;
            4'h6: lit_d = 7'h7D;   // top bar kept on six
            4'h7: lit_d = 7'h07;
            4'h8: lit_d = 7'h7F;
            4'h9: lit_d = 7'h6F;   // bottom bar kept on nine
            4'hA: lit_d = 7'h77;
            4'hB: lit_d = 7'h7C;   // lowercase b
            4'hC: lit_d = 7'h39;
            4'hD: lit_d = 7'h5E;   // lowercase d
            4'hE: lit_d = 7'h79;
            default: lit_d = 7'h71;
        endcase
    end

    assign lit = lit_d;

    always_comb begin
        // R1
        glyph_span_chk: assert ($countones(lit) >= 2)
            else $error("glyph for code %0h lights too few segments", code);
    end
endmodule

// File: rtl/hexseg_ctrl.sv
module hexseg_ctrl
    import hexseg_pkg::*;
(
    input  code_t code,
    input  logic  lamp_n,
    input  logic  blank_n,
    input  logic  rip_in_n,
    output show_e mode,
    output logic  rip_out_n
);
    ctrl_t ctrl_d;
    logic  is_zero;

    assign is_zero = (code == '0);

    always_comb begin
        ctrl_d           = '0;
        ctrl_d.mode      = SHOW_GLYPH;
        ctrl_d.rip_out_n = 1'b1;
        if (!rip_in_n && is_zero && lamp_n) begin
            ctrl_d.rip_out_n = 1'b0;
        end
        if (!blank_n) begin
            ctrl_d.mode = SHOW_DARK;
        end else if (!lamp_n) begin
            ctrl_d.mode = SHOW_ALL;
        end else if (!ctrl_d.rip_out_n) begin
            ctrl_d.mode = SHOW_DARK;
        end
    end

    assign mode      = ctrl_d.mode;
    assign rip_out_n = ctrl_d.rip_out_n;

    always_comb begin
        // R5
        lamp_mode_chk: assert (!(blank_n && !lamp_n) || mode == SHOW_ALL)
            else $error("lamp test did not select full lighting");
    end
endmodule

// File: rtl/hexseg_digit.sv
module hexseg_digit
    import hexseg_pkg::*;
(
    input  logic [3:0] digit_val,
    input  logic       lamp_test_n,
    input  logic       blank_n,
    input  logic       rb_in_n,
    output logic [6:0] seg_n,
    output logic       rb_out_n
);
    seg_t  lit;
    show_e mode;
    logic  rip_n;

    hexseg_glyph u_glyph (
        .code (digit_val),
        .lit  (lit)
    );

    hexseg_ctrl u_ctrl (
        .code      (digit_val),
        .lamp_n    (lamp_test_n),
        .blank_n   (blank_n),
        .rip_in_n  (rb_in_n),
        .mode      (mode),
        .rip_out_n (rip_n)
    );

    for (genvar s = 0; s < SEG_W; s++) begin : g_seg
        always_comb begin
            unique case (mode)
                SHOW_ALL:  seg_n[s] = 1'b0;
                SHOW_DARK: seg_n[s] = 1'b1;
                default:   seg_n[s] = ~lit[s];
            endcase
        end
    end

    assign rb_out_n = rip_n;

    always_comb begin
        // R4
        if (!blank_n) begin
            blank_off_chk: assert (seg_n == 7'h7F)
                else $error("blanked digit shows segments");
        end
        // R5
        if (blank_n && !lamp_test_n) begin
            lamp_on_chk: assert (seg_n == 7'h00)
                else $error("lamp test leaves segments dark");
        end
        // R6
        if (!rb_out_n) begin
            ripple_dark_chk: assert (seg_n == 7'h7F)
                else $error("ripple output low on a lit digit");
        end
        // R7
        if (!rb_out_n) begin
            ripple_cond_chk: assert (digit_val == 4'h0 && lamp_test_n && !rb_in_n)
                else $error("ripple output low outside a blanked zero");
        end
    end
endmodule

// File: tb/hexseg_digit_tb.sv
module hexseg_digit_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  CHAIN_N    = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0] val;
    logic       lt_n, bl_n, rbi_n;
    logic [6:0] seg_n;
    logic       rbo_n;

    hexseg_digit u_dut (
        .digit_val(val), .lamp_test_n(lt_n), .blank_n(bl_n),
        .rb_in_n(rbi_n), .seg_n(seg_n), .rb_out_n(rbo_n)
    );

    // four-digit row, index 3 is the leftmost digit
    logic [15:0] row_val;
    logic [CHAIN_N:0] rip;
    logic [6:0] row_seg [CHAIN_N];
    assign rip[CHAIN_N] = 1'b0;
    for (genvar k = CHAIN_N - 1; k >= 0; k--) begin : g_row
        hexseg_digit u_cell (
            .digit_val(row_val[4*k +: 4]), .lamp_test_n(1'b1), .blank_n(1'b1),
            .rb_in_n(rip[k+1]), .seg_n(row_seg[k]), .rb_out_n(rip[k])
        );
    end

    function automatic logic [6:0] ref_on(input logic [3:0] c);
        case (c)
            4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
            4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
            4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
            4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] v, input logic l, input logic b, input logic r);
        @(posedge clk);
        val = v; lt_n = l; bl_n = b; rbi_n = r;
        @(negedge clk);
    endtask

    task automatic t_start;
        apply(4'h8, 1'b1, 1'b0, 1'b1);
        chk("R4 start blanked", {1'b0, seg_n}, 8'h7F);
        chk("R7 start ripple", {7'b0, rbo_n}, 8'h01);
    endtask

    task automatic t_sweep;
        for (int c = 0; c < 16; c++) begin
            for (int m = 0; m < 8; m++) begin
                logic l, b, r, z;
                logic [6:0] es;
                l = m[0]; b = m[1]; r = m[2];
                apply(c[3:0], l, b, r);
                z = (!r && c == 0 && l);
                if (!b)      es = 7'h7F;           // R4
                else if (!l) es = 7'h00;           // R5
                else if (z)  es = 7'h7F;           // R6
                else         es = ~ref_on(c[3:0]); // R1 R3 R8
                chk(c < 10 ? "R1 sweep seg" : "R3 sweep seg", {1'b0, seg_n}, {1'b0, es});
                chk(z ? "R6 sweep ripple" : "R7 sweep ripple", {7'b0, rbo_n}, {7'b0, !z});
            end
        end
    endtask

    task automatic t_shapes;
        apply(4'h6, 1'b1, 1'b1, 1'b1);
        chk("R2 six top bar", {7'b0, seg_n[0]}, 8'h00);
        apply(4'h9, 1'b1, 1'b1, 1'b1);
        chk("R2 nine bottom bar", {7'b0, seg_n[3]}, 8'h00);
        apply(4'hB, 1'b1, 1'b1, 1'b1);
        chk("R3 lowercase b", {1'b0, seg_n}, 8'h03);
        apply(4'hD, 1'b1, 1'b1, 1'b1);
        chk("R3 lowercase d", {1'b0, seg_n}, 8'h21);
        apply(4'h5, 1'b1, 1'b1, 1'b0);
        chk("R8 ripple on non-zero", {1'b0, seg_n}, 8'h12);
        apply(4'h0, 1'b0, 1'b1, 1'b0);
        chk("R7 lamp test zero ripple", {7'b0, rbo_n}, 8'h01);
    endtask

    task automatic t_row(input logic [15:0] v);
        logic lead;
        @(posedge clk);
        row_val = v;
        @(negedge clk);
        lead = 1'b1;
        for (int k = CHAIN_N - 1; k >= 0; k--) begin
            logic [3:0] nib;
            nib = v[4*k +: 4];
            if (lead && nib == 4'h0) begin
                chk("R9 leading zero dark", {1'b0, row_seg[k]}, 8'h7F);
            end else begin
                lead = 1'b0;
                chk("R9 digit shown", {1'b0, row_seg[k]}, {1'b0, ~ref_on(nib)});
            end
        end
    endtask

    initial begin
        val = '0; lt_n = 1'b1; bl_n = 1'b0; rbi_n = 1'b1; row_val = '0;
        t_start();
        t_sweep();
        t_shapes();
        t_row(16'h0007);
        t_row(16'h0100);
        t_row(16'h0000);
        t_row(16'h1000);
        t_row(16'h0A0F);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule